// File: doc/BRIEF.md
# Interrupt Line Trigger and Delivery Unit

This block watches one raw interrupt input and turns it into delivery requests for an interrupt-delivery port. The input is resynchronised into the local clock domain. It is then judged as either level-sensitive or edge-sensitive, with a selectable active polarity. A line that is active and enabled raises a single request. The request carries a 32-bit destination word and a 32-bit command word, and both are presented during the same one-cycle valid pulse.

A single pending flag records that a request has been raised and not yet acknowledged. While the flag is set, further activity produces no new request. An end-of-interrupt strobe clears the flag. If the line is level-sensitive, still asserted and enabled at that point, a fresh request goes out straight away. Software-style configuration arrives through independent write strobes for the mode, the enable bit, the CPU mask and the vector.

Top module: `irq_line_trigger`

## Requirements
- R1: After reset no request is presented, both command outputs read zero, the enable bit is 0, the pending flag is 0, the CPU mask is 0x01 and the vector is 0x00. The line is in edge mode with falling-edge polarity, and the remembered previous level is 0.
- R2: The input passes through two synchronising flops, and the request is registered. An input change driven before rising edge k first shows `reqValid` high after rising edge k+2.
- R3: In level mode (`cfgLevel`=1), the line is active whenever the synchronised input equals `cfgPolarity`.
- R4: In edge mode (`cfgLevel`=0), only a 0-to-1 transition is active when polarity is 1, and only a 1-to-0 transition when polarity is 0. The previous level is updated on every cycle, whether or not the line is enabled.
- R5: An active line raises a request only while the enable bit is 1.
- R6: Raising a request sets the pending flag. While the flag is set, no further request is raised.
- R7: An end-of-interrupt with the pending flag set clears it. A level-mode line that is still active and enabled is re-raised in that same cycle. An edge-mode line is not re-raised.
- R8: An end-of-interrupt with the pending flag clear changes nothing.
- R9: When the CPU mask is zero, a raised request still sets the pending flag, but no valid pulse is presented.
- R10: `reqHigh` carries the CPU mask in bits 31:24 with zeros below. `reqLow` is the 8-bit vector ORed with 0x4800.
- R11: Each request is a valid pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 1 | Raw asynchronous interrupt input |
| cfgModeWe | input | 1 | Write strobe for mode and polarity |
| cfgLevel | input | 1 | 1 = level-sensitive, 0 = edge-sensitive |
| cfgPolarity | input | 1 | 1 = high/rising active, 0 = low/falling active |
| cfgEnableWe | input | 1 | Write strobe for the enable bit |
| cfgEnable | input | 1 | Enable value |
| cfgMaskWe | input | 1 | Write strobe for the CPU mask |
| cfgCpuMask | input | 8 | CPU mask value |
| cfgVectorWe | input | 1 | Write strobe for the vector |
| cfgVector | input | 8 | Vector value |
| eoiStrobe | input | 1 | End-of-interrupt pulse |
| reqValid | output | 1 | One-cycle delivery request |
| reqHigh | output | 32 | Destination word (mask in 31:24) |
| reqLow | output | 32 | Command word (vector ORed with 0x4800) |

## Verification
The one-cycle pulse property depends on one condition: no end-of-interrupt arrives in the cycle that a request is presented. Without that, a still-active level line could be re-raised back to back. The stimulus always waits several cycles after a request before it pulses the end-of-interrupt strobe. Configuration writes are made only while the line state is known, so every request the bench expects is placed in the scoreboard queue before the event that causes it.

// File: rtl/irq_line_pkg.sv
package irq_line_pkg;
  typedef struct packed {
    logic issue;
    logic loadMask;
    logic loadVector;
  } ctrlStrobes_t;

  localparam logic [31:0] CMD_TAG = 32'h0000_4800;
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineOut
);
  logic [STAGES-1:0] chain;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rstN) chain[0] <= 1'b0;
        else       chain[0] <= lineIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rstN) chain[i] <= 1'b0;
        else       chain[i] <= chain[i-1];
      end
    end
  end

  assign lineOut = chain[STAGES-1];
endmodule

// File: rtl/irq_line_ctrl.sv
module irq_line_ctrl
  import irq_line_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         syncLine,
  input  logic         cfgModeWe,
  input  logic         cfgLevel,
  input  logic         cfgPolarity,
  input  logic         cfgEnableWe,
  input  logic         cfgEnable,
  input  logic         cfgMaskWe,
  input  logic         cfgVectorWe,
  input  logic         eoiStrobe,
  output ctrlStrobes_t strobes,
  output logic         pendingFlag,
  output logic         enableFlag
);
  logic levelMode;
  logic polarity;
  logic lastLevel;
  logic lineActive;
  logic kick;
  logic pendKept;

  always_comb begin
    if (levelMode)     lineActive = (syncLine == polarity);
    else if (polarity) lineActive = syncLine & ~lastLevel;
    else               lineActive = ~syncLine & lastLevel;
  end

  assign kick     = enableFlag & lineActive;
  assign pendKept = pendingFlag & ~eoiStrobe;

  always_comb begin
    strobes            = '0;
    strobes.issue      = kick & ~pendKept;
    strobes.loadMask   = cfgMaskWe;
    strobes.loadVector = cfgVectorWe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelMode   <= 1'b0;
      polarity    <= 1'b0;
      enableFlag  <= 1'b0;
      pendingFlag <= 1'b0;
      lastLevel   <= 1'b0;
    end else begin
      lastLevel   <= syncLine;
      pendingFlag <= pendKept | kick;
      if (cfgModeWe) begin
        levelMode <= cfgLevel;
        polarity  <= cfgPolarity;
      end
      if (cfgEnableWe) enableFlag <= cfgEnable;
    end
  end
endmodule

// File: rtl/irq_line_datapath.sv
module irq_line_datapath
  import irq_line_pkg::*;
#(
  parameter int CPU_W = 8,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [CPU_W-1:0] cfgCpuMask,
  input  logic [VEC_W-1:0] cfgVector,
  output logic             reqValid,
  output logic [31:0]      reqHigh,
  output logic [31:0]      reqLow
);
  localparam int HIGH_PAD = 32 - CPU_W;
  localparam int LOW_PAD  = 32 - VEC_W;
  localparam logic [CPU_W-1:0] MASK_RESET = CPU_W'(1);

  logic [CPU_W-1:0] cpuMask;
  logic [VEC_W-1:0] vectorReg;
  logic             maskLive;

  assign maskLive = |cpuMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cpuMask   <= MASK_RESET;
      vectorReg <= '0;
      reqValid  <= 1'b0;
      reqHigh   <= '0;
      reqLow    <= '0;
    end else begin
      if (strobes.loadMask)   cpuMask   <= cfgCpuMask;
      if (strobes.loadVector) vectorReg <= cfgVector;
      reqValid <= strobes.issue & maskLive;
      if (strobes.issue && maskLive) begin
        reqHigh <= {cpuMask, {HIGH_PAD{1'b0}}};
        reqLow  <= {{LOW_PAD{1'b0}}, vectorReg} | CMD_TAG;
      end
    end
  end
endmodule

// File: rtl/irq_line_trigger.sv
module irq_line_trigger
  import irq_line_pkg::*;
#(
  parameter int CPU_W       = 8,
  parameter int VEC_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineIn,
  input  logic             cfgModeWe,
  input  logic             cfgLevel,
  input  logic             cfgPolarity,
  input  logic             cfgEnableWe,
  input  logic             cfgEnable,
  input  logic             cfgMaskWe,
  input  logic [CPU_W-1:0] cfgCpuMask,
  input  logic             cfgVectorWe,
  input  logic [VEC_W-1:0] cfgVector,
  input  logic             eoiStrobe,
  output logic             reqValid,
  output logic [31:0]      reqHigh,
  output logic [31:0]      reqLow
);
  logic         syncLine;
  ctrlStrobes_t strobes;
  logic         pendingFlag;
  logic         enableFlag;

  irq_line_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .lineOut(syncLine)
  );

  irq_line_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .syncLine(syncLine),
    .cfgModeWe(cfgModeWe), .cfgLevel(cfgLevel), .cfgPolarity(cfgPolarity),
    .cfgEnableWe(cfgEnableWe), .cfgEnable(cfgEnable),
    .cfgMaskWe(cfgMaskWe), .cfgVectorWe(cfgVectorWe),
    .eoiStrobe(eoiStrobe), .strobes(strobes),
    .pendingFlag(pendingFlag), .enableFlag(enableFlag)
  );

  irq_line_datapath #(.CPU_W(CPU_W), .VEC_W(VEC_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cfgCpuMask(cfgCpuMask), .cfgVector(cfgVector),
    .reqValid(reqValid), .reqHigh(reqHigh), .reqLow(reqLow)
  );
endmodule

// File: rtl/irq_line_checker.sv
module irq_line_checker (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic [31:0] reqHigh,
  input logic [31:0] reqLow,
  input logic        eoiStrobe,
  input logic        pendingFlag,
  input logic        enableFlag
);
  a_r9_mask_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqHigh[31:24] != 8'h00));

  a_r10_cmd_format: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqLow[31:16] == 16'h0000 && reqLow[14:8] == 7'h48 && reqHigh[23:0] == 24'h0));

  a_r6_pending_held: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> pendingFlag);

  a_r5_enabled_source: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> $past(enableFlag));

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !eoiStrobe) |=> !reqValid);

  a_r7_eoi_clears_edge: assert property (@(posedge clk) disable iff (!rstN)
    (pendingFlag && eoiStrobe && !enableFlag) |=> !pendingFlag);
endmodule

bind irq_line_trigger irq_line_checker chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqHigh(reqHigh),
  .reqLow(reqLow), .eoiStrobe(eoiStrobe),
  .pendingFlag(pendingFlag), .enableFlag(enableFlag)
);

// File: tb/irq_line_trigger_tb_top.sv
module irq_line_trigger_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineIn = 1'b0;
  logic        cfgModeWe = 1'b0, cfgLevel = 1'b0, cfgPolarity = 1'b0;
  logic        cfgEnableWe = 1'b0, cfgEnable = 1'b0;
  logic        cfgMaskWe = 1'b0, cfgVectorWe = 1'b0;
  logic [7:0]  cfgCpuMask = 8'h00, cfgVector = 8'h00;
  logic        eoiStrobe = 1'b0;
  logic        reqValid;
  logic [31:0] reqHigh, reqLow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] expHi[$];
  logic [31:0] expLo[$];
  string       expTag[$];

  always #10 clk = ~clk;

  irq_line_trigger dut_i (
    .clk(clk), .rstN(rstN), .lineIn(lineIn),
    .cfgModeWe(cfgModeWe), .cfgLevel(cfgLevel), .cfgPolarity(cfgPolarity),
    .cfgEnableWe(cfgEnableWe), .cfgEnable(cfgEnable),
    .cfgMaskWe(cfgMaskWe), .cfgCpuMask(cfgCpuMask),
    .cfgVectorWe(cfgVectorWe), .cfgVector(cfgVector),
    .eoiStrobe(eoiStrobe), .reqValid(reqValid),
    .reqHigh(reqHigh), .reqLow(reqLow)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expectReq(input logic [31:0] hi, input logic [31:0] lo, input string tag);
    expHi.push_back(hi); expLo.push_back(lo); expTag.push_back(tag);
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    check(expHi.size() == 0, tag, 32'(expHi.size()), 32'd0);
    expHi.delete(); expLo.delete(); expTag.delete();
  endtask

  task automatic setLine(input logic v);
    @(negedge clk); lineIn = v;
  endtask

  task automatic writeMode(input logic lvl, input logic pol);
    @(negedge clk); cfgModeWe = 1'b1; cfgLevel = lvl; cfgPolarity = pol;
    @(negedge clk); cfgModeWe = 1'b0;
  endtask

  task automatic writeEnable(input logic en);
    @(negedge clk); cfgEnableWe = 1'b1; cfgEnable = en;
    @(negedge clk); cfgEnableWe = 1'b0;
  endtask

  task automatic writeMask(input logic [7:0] m);
    @(negedge clk); cfgMaskWe = 1'b1; cfgCpuMask = m;
    @(negedge clk); cfgMaskWe = 1'b0;
  endtask

  task automatic writeVector(input logic [7:0] v);
    @(negedge clk); cfgVectorWe = 1'b1; cfgVector = v;
    @(negedge clk); cfgVectorWe = 1'b0;
  endtask

  task automatic pulseEoi();
    @(negedge clk); eoiStrobe = 1'b1;
    @(negedge clk); eoiStrobe = 1'b0;
  endtask

  // Monitor: pops the scoreboard on every request
  always @(negedge clk) begin
    if (rstN && reqValid) begin
      if (expHi.size() == 0) begin
        check(1'b0, "unexpected request", reqLow, 32'h0);
      end else begin
        logic [31:0] h, l;
        string t;
        h = expHi.pop_front(); l = expLo.pop_front(); t = expTag.pop_front();
        check(reqHigh == h, {t, " high"}, reqHigh, h);
        check(reqLow == l, {t, " low"}, reqLow, l);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(reqValid == 1'b0, "R1 reqValid", 32'(reqValid), 32'd0);
    check(reqHigh == 32'h0, "R1 reqHigh", reqHigh, 32'h0);
    check(reqLow == 32'h0, "R1 reqLow", reqLow, 32'h0);

    // R5: rising edge while disabled is ignored
    writeMode(1'b0, 1'b1);
    setLine(1'b1); waitCyc(6);
    drained("R5 disabled edge");
    setLine(1'b0); waitCyc(6);

    // R1 reset mask 0x01, R2 latency, R4 rising edge, R11 single pulse
    writeEnable(1'b1);
    expectReq(32'h0100_0000, 32'h0000_4800, "R4 rising edge");
    @(negedge clk); lineIn = 1'b1;
    @(negedge clk); check(reqValid == 1'b0, "R2 latency edge1", 32'(reqValid), 32'd0);
    @(negedge clk); check(reqValid == 1'b0, "R2 latency edge2", 32'(reqValid), 32'd0);
    @(negedge clk); check(reqValid == 1'b1, "R2 latency edge3", 32'(reqValid), 32'd1);
    @(negedge clk); check(reqValid == 1'b0, "R11 pulse width", 32'(reqValid), 32'd0);
    waitCyc(4);
    drained("R1 reset mask request");

    // R6: second edge while pending raises nothing
    setLine(1'b0); waitCyc(4);
    setLine(1'b1); waitCyc(6);
    drained("R6 pending suppress");

    // R7: EOI in edge mode does not re-raise
    pulseEoi(); waitCyc(6);
    drained("R7 edge no refire");
    setLine(1'b0); waitCyc(4);
    expectReq(32'h0100_0000, 32'h0000_4800, "R7 edge after eoi");
    setLine(1'b1); waitCyc(6);
    drained("R7 edge after eoi");
    pulseEoi(); waitCyc(3);

    // R8: EOI with pending clear has no effect
    pulseEoi(); waitCyc(6);
    drained("R8 idle eoi");

    // R4 falling edge
    writeMode(1'b0, 1'b0);
    expectReq(32'h0100_0000, 32'h0000_4800, "R4 falling edge");
    setLine(1'b0); waitCyc(6);
    drained("R4 falling edge");
    pulseEoi(); waitCyc(3);

    // R10 command words
    writeMask(8'hA5); writeVector(8'h3C); writeMode(1'b0, 1'b1);
    expectReq(32'hA500_0000, 32'h0000_483C, "R10 format");
    setLine(1'b1); waitCyc(6);
    drained("R10 format");
    pulseEoi(); setLine(1'b0); waitCyc(4);

    // R3 level high, R7 level refire
    writeMode(1'b1, 1'b1); waitCyc(4);
    drained("R3 level inactive");
    expectReq(32'hA500_0000, 32'h0000_483C, "R3 level high");
    setLine(1'b1); waitCyc(8);
    drained("R3 level held once");
    expectReq(32'hA500_0000, 32'h0000_483C, "R7 level refire");
    pulseEoi(); waitCyc(6);
    drained("R7 level refire");
    setLine(1'b0); waitCyc(4);
    pulseEoi(); waitCyc(6);
    drained("R7 level released");
    expectReq(32'hA500_0000, 32'h0000_483C, "R3 level again");
    setLine(1'b1); waitCyc(6);
    drained("R3 level again");
    setLine(1'b0); waitCyc(4); pulseEoi(); waitCyc(3);

    // R3 level low polarity: active at once on the mode write
    expectReq(32'hA500_0000, 32'h0000_483C, "R3 level low");
    writeMode(1'b1, 1'b0); waitCyc(6);
    drained("R3 level low");
    setLine(1'b1); waitCyc(4); pulseEoi(); waitCyc(6);
    drained("R3 level low released");

    // R9: zero mask sets pending silently
    writeMask(8'h00);
    writeMode(1'b1, 1'b1); waitCyc(6);
    drained("R9 zero mask silent");
    writeMask(8'h02); waitCyc(6);
    drained("R9 pending kept");
    expectReq(32'h0200_0000, 32'h0000_483C, "R9 refire after eoi");
    pulseEoi(); waitCyc(6);
    drained("R9 refire after eoi");

    // R5: disabled level line not re-raised by EOI
    writeEnable(1'b0);
    pulseEoi(); waitCyc(6);
    drained("R5 disabled level");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule